// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a trap request and decides which privilege level handles it. The request carries a cause word, the PC of the trapping instruction and an optional faulting address. The handler is either supervisor or machine. The choice depends on the current privilege and on two delegation masks, one for interrupts and one for exceptions. In the same clock edge the block writes the chosen level's cause, exception-PC and bad-address registers. It also pushes the status enable stack, switches privilege and redirects the PC to that level's trap vector.

A breakpoint taken while a debugger is attached does not go through delegation. It enters debug mode: the block records a software-breakpoint cause, saves the trapping PC and jumps to a fixed debug entry address. A small load port sets the privilege, the status enable fields and the machine vector. A separate strobe marks that a load reservation has been taken, so the block can invalidate it on trap entry.

The privilege level is the block's state machine, with three named states. USER encodes as 00, SUPV as 01 and MACH as 11. The transitions are:
- reset goes to MACH;
- a trap that is not delegated goes to MACH from any state;
- a delegated trap goes to SUPV from USER or SUPV;
- a debug entry stays in the current state;
- a privilege load goes to the loaded state, if that value is legal.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the privilege is MACH and the PC is RESET_PC. The machine vector is MTVEC_RESET, the reservation is invalid and the status is zero.
- R2: A trap goes to machine if any of these holds: the current privilege is MACH, the cause bit index is XLEN or more, or the selected delegation bit is 0.
- R3: On a supervisor trap, the PC takes the supervisor vector input with its low two bits cleared. The supervisor cause and exception PC are written. The supervisor bad address is written only when the trap carries an address.
- R4: On a supervisor trap, status bit 5 (supervisor previous enable) takes the status bit whose index equals the current privilege code. Bit 8 takes privilege bit 0, bit 1 clears and the privilege becomes SUPV.
- R5: On a machine trap, the PC takes the machine vector. The machine cause, exception PC and (when an address is carried) bad address are written. Bit 7 takes the current-privilege enable bit, bits 12:11 take the privilege, bit 3 clears and the privilege becomes MACH.
- R6: A cause with its MSB set is an interrupt. It indexes the interrupt mask with the MSB cleared. Any other cause indexes the exception mask.
- R7: Cause 3 with the debugger attached gives debug mode instead: debug cause 1, debug PC equal to the trap PC, PC equal to DEBUG_ENTRY. Privilege, status, reservation and the level registers are unchanged. Without the debugger, cause 3 is an ordinary trap.
- R8: Every trap other than a debug entry invalidates the load reservation.
- R9: A privilege load of code 10 is ignored. The load selects are 0 for privilege, 1 for status, 2 for machine vector and 3 for nothing.
- R10: When a trap and either a load or a reservation strobe fall in the same cycle, the trap takes effect and the other input is dropped.
- R11: A status load keeps only bits 0, 1, 3, 4, 5, 7, 8, 11 and 12.
- R12: A machine vector load clears the low two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| trap_valid | input | 1 | trap request this cycle |
| trap_cause | input | XLEN | cause word, MSB marks an interrupt |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_has_addr | input | 1 | trap carries a faulting address |
| trap_addr | input | XLEN | faulting address |
| dbg_attached | input | 1 | a debugger is connected |
| exc_deleg | input | XLEN | exception delegation mask |
| irq_deleg | input | XLEN | interrupt delegation mask |
| svec_in | input | XLEN | supervisor trap vector |
| ld_en | input | 1 | state load strobe |
| ld_sel | input | 2 | load target |
| ld_data | input | XLEN | load value |
| resv_set | input | 1 | load reservation acquired |
| pc_o | output | XLEN | next PC |
| priv_o | output | 2 | current privilege |
| status_o | output | XLEN | status enable stack |
| mvec_o | output | XLEN | machine trap vector |
| m_epc_o | output | XLEN | machine exception PC |
| m_cause_o | output | XLEN | machine cause |
| m_bad_o | output | XLEN | machine bad address |
| s_epc_o | output | XLEN | supervisor exception PC |
| s_cause_o | output | XLEN | supervisor cause |
| s_bad_o | output | XLEN | supervisor bad address |
| dbg_pc_o | output | XLEN | debug saved PC |
| dbg_cause_o | output | 3 | debug entry cause |
| resv_o | output | 1 | load reservation valid |

## Verification
A trap can arrive in the same cycle as a privilege load and a reservation strobe. The bench drives all three on one edge and expects the trap outcome: the privilege is taken from the pre-trap state and the reservation ends up invalid. A second overlap puts a breakpoint cause together with an attached debugger and a set reservation. There the bench expects the reservation and the privilege to survive and the level registers to stay unchanged.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        PRV_USER = 2'b00,
        PRV_SUPV = 2'b01,
        PRV_MACH = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        LD_PRIV   = 2'd0,
        LD_STATUS = 2'd1,
        LD_MVEC   = 2'd2,
        LD_NONE   = 2'd3
    } ld_sel_e;

    localparam int ST_UIE  = 0;
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_UPIE = 4;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP0 = 11;
    localparam int ST_MPP1 = 12;
endpackage

// File: rtl/trap_route.sv
module trap_route #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] exc_mask,
    input  logic [XLEN-1:0] irq_mask,
    output logic            to_super
);
    localparam int IDXW = $clog2(XLEN);
    localparam logic [XLEN-1:0] LIMIT = XLEN'(XLEN);

    logic            is_irq;
    logic [XLEN-1:0] bit_idx;
    logic [XLEN-1:0] sel_mask;
    logic            in_range;
    logic            mask_bit;

    always_comb begin
        is_irq   = cause[XLEN-1];
        bit_idx  = {1'b0, cause[XLEN-2:0]};
        sel_mask = is_irq ? irq_mask : exc_mask;
        in_range = (bit_idx < LIMIT);
        mask_bit = sel_mask[bit_idx[IDXW-1:0]];
        to_super = (priv <= 2'b01) && in_range && mask_bit;
    end
endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            has_addr,
    input  logic [XLEN-1:0] cause,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] bad_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            bad_q   <= '0;
        end else if (wr) begin
            epc_q   <= pc;
            cause_q <= cause;
            if (has_addr)
                bad_q <= addr;
        end
    end

    a_r3_bad_only_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !has_addr) |=> $stable(bad_q));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] RESET_PC    = 32'h0000_1000,
    parameter logic [XLEN-1:0] MTVEC_RESET = 32'h0000_0100,
    parameter logic [XLEN-1:0] DEBUG_ENTRY = 32'h0000_0800,
    parameter int              BRK_CAUSE   = 3,
    parameter logic [2:0]      DBG_SWBP    = 3'd1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            trap_has_addr,
    input  logic [XLEN-1:0] trap_addr,
    input  logic            dbg_attached,
    input  logic [XLEN-1:0] exc_deleg,
    input  logic [XLEN-1:0] irq_deleg,
    input  logic [XLEN-1:0] svec_in,
    input  logic            ld_en,
    input  logic [1:0]      ld_sel,
    input  logic [XLEN-1:0] ld_data,
    input  logic            resv_set,
    output logic [XLEN-1:0] pc_o,
    output logic [1:0]      priv_o,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] mvec_o,
    output logic [XLEN-1:0] m_epc_o,
    output logic [XLEN-1:0] m_cause_o,
    output logic [XLEN-1:0] m_bad_o,
    output logic [XLEN-1:0] s_epc_o,
    output logic [XLEN-1:0] s_cause_o,
    output logic [XLEN-1:0] s_bad_o,
    output logic [XLEN-1:0] dbg_pc_o,
    output logic [2:0]      dbg_cause_o,
    output logic            resv_o
);
    localparam int NLVL = 2;
    localparam logic [XLEN-1:0] BRK_W   = XLEN'(BRK_CAUSE);
    localparam logic [XLEN-1:0] ST_KEEP = XLEN'((1 << ST_UIE) | (1 << ST_SIE) | (1 << ST_MIE)
        | (1 << ST_UPIE) | (1 << ST_SPIE) | (1 << ST_MPIE) | (1 << ST_SPP)
        | (1 << ST_MPP0) | (1 << ST_MPP1));
    localparam logic [XLEN-1:0] ALIGN = ~XLEN'(3);

    priv_e           priv_q, priv_d;
    logic [XLEN-1:0] pc_q, status_q, mvec_q, dpc_q;
    logic [2:0]      dcause_q;
    logic            resv_q;

    logic to_super, dbg_hit, take_trap, cur_ie;
    logic ld_priv, ld_stat, ld_mvec;

    trap_route #(.XLEN(XLEN)) u_route (
        .cause    (trap_cause),
        .priv     (priv_q),
        .exc_mask (exc_deleg),
        .irq_mask (irq_deleg),
        .to_super (to_super)
    );

    always_comb begin
        dbg_hit   = trap_valid && dbg_attached && (trap_cause == BRK_W);
        take_trap = trap_valid && !dbg_hit;
        cur_ie    = status_q[priv_q];
        ld_priv   = !trap_valid && ld_en && (ld_sel == LD_PRIV);
        ld_stat   = !trap_valid && ld_en && (ld_sel == LD_STATUS);
        ld_mvec   = !trap_valid && ld_en && (ld_sel == LD_MVEC);
    end

    // Privilege state machine: next-state logic
    always_comb begin
        priv_d = priv_q;
        if (take_trap) begin
            priv_d = to_super ? PRV_SUPV : PRV_MACH;
        end else if (ld_priv) begin
            unique case (ld_data[1:0])
                2'b00:   priv_d = PRV_USER;
                2'b01:   priv_d = PRV_SUPV;
                2'b11:   priv_d = PRV_MACH;
                default: priv_d = priv_q;
            endcase
        end
    end

    // Privilege state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            priv_q <= PRV_MACH;
        else
            priv_q <= priv_d;
    end

    // Output and architectural state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            status_q <= '0;
            mvec_q   <= MTVEC_RESET;
            dpc_q    <= '0;
            dcause_q <= '0;
            resv_q   <= 1'b0;
        end else if (dbg_hit) begin
            dcause_q <= DBG_SWBP;
            dpc_q    <= trap_pc;
            pc_q     <= DEBUG_ENTRY;
        end else if (take_trap) begin
            resv_q <= 1'b0;
            if (to_super) begin
                pc_q               <= svec_in & ALIGN;
                status_q[ST_SPIE]  <= cur_ie;
                status_q[ST_SPP]   <= priv_q[0];
                status_q[ST_SIE]   <= 1'b0;
            end else begin
                pc_q                       <= mvec_q;
                status_q[ST_MPIE]          <= cur_ie;
                status_q[ST_MPP1:ST_MPP0]  <= priv_q;
                status_q[ST_MIE]           <= 1'b0;
            end
        end else begin
            if (resv_set)
                resv_q <= 1'b1;
            if (ld_stat)
                status_q <= ld_data & ST_KEEP;
            if (ld_mvec)
                mvec_q <= ld_data & ALIGN;
        end
    end

    logic [XLEN-1:0] epc_w   [NLVL];
    logic [XLEN-1:0] cause_w [NLVL];
    logic [XLEN-1:0] bad_w   [NLVL];

    // Level 0 is supervisor, level 1 is machine
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic lvl_wr;
        assign lvl_wr = take_trap && ((g == 0) ? to_super : !to_super);
        trap_level_regs #(.XLEN(XLEN)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (lvl_wr),
            .has_addr (trap_has_addr),
            .cause    (trap_cause),
            .pc       (trap_pc),
            .addr     (trap_addr),
            .epc_q    (epc_w[g]),
            .cause_q  (cause_w[g]),
            .bad_q    (bad_w[g])
        );
    end

    assign pc_o        = pc_q;
    assign priv_o      = priv_q;
    assign status_o    = status_q;
    assign mvec_o      = mvec_q;
    assign s_epc_o     = epc_w[0];
    assign s_cause_o   = cause_w[0];
    assign s_bad_o     = bad_w[0];
    assign m_epc_o     = epc_w[1];
    assign m_cause_o   = cause_w[1];
    assign m_bad_o     = bad_w[1];
    assign dbg_pc_o    = dpc_q;
    assign dbg_cause_o = dcause_q;
    assign resv_o      = resv_q;

    a_r2_machine_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && priv_q == PRV_MACH) |=> (priv_q == PRV_MACH));
    a_r3_super_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && to_super) |=> (pc_o == ($past(svec_in) & ALIGN)));
    a_r5_machine_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && !to_super) |=> (pc_o == $past(mvec_q)));
    a_r7_debug_keeps_priv: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit |=> ($stable(priv_q) && $stable(status_q) && pc_o == DEBUG_ENTRY));
    a_r8_resv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> !resv_o);
    a_r9_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
        priv_q != 2'b10);
endmodule

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;
    localparam int XLEN = 32;
    localparam logic [31:0] RST_PC = 32'h1000;
    localparam logic [31:0] MVEC0  = 32'h0100;
    localparam logic [31:0] DBGPC  = 32'h0800;

    logic clk = 0, rst_n = 0;
    logic trap_valid = 0, trap_has_addr = 0, dbg_attached = 0;
    logic [31:0] trap_cause = 0, trap_pc = 0, trap_addr = 0;
    logic [31:0] exc_deleg = 0, irq_deleg = 0, svec_in = 32'h202;
    logic ld_en = 0, resv_set = 0;
    logic [1:0] ld_sel = 0;
    logic [31:0] ld_data = 0;
    logic [31:0] pc_o, status_o, mvec_o, m_epc_o, m_cause_o, m_bad_o;
    logic [31:0] s_epc_o, s_cause_o, s_bad_o, dbg_pc_o;
    logic [1:0] priv_o;
    logic [2:0] dbg_cause_o;
    logic resv_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .trap_has_addr(trap_has_addr), .trap_addr(trap_addr),
        .dbg_attached(dbg_attached), .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
        .svec_in(svec_in), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .resv_set(resv_set), .pc_o(pc_o), .priv_o(priv_o), .status_o(status_o),
        .mvec_o(mvec_o), .m_epc_o(m_epc_o), .m_cause_o(m_cause_o), .m_bad_o(m_bad_o),
        .s_epc_o(s_epc_o), .s_cause_o(s_cause_o), .s_bad_o(s_bad_o),
        .dbg_pc_o(dbg_pc_o), .dbg_cause_o(dbg_cause_o), .resv_o(resv_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        ld_en = 1; ld_sel = sel; ld_data = data;
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic do_resv();
        @(negedge clk);
        resv_set = 1;
        @(negedge clk);
        resv_set = 0;
    endtask

    task automatic do_trap(logic [31:0] c, logic [31:0] p, logic ha, logic [31:0] a);
        @(negedge clk);
        trap_valid = 1; trap_cause = c; trap_pc = p; trap_has_addr = ha; trap_addr = a;
        @(negedge clk);
        trap_valid = 0; trap_has_addr = 0;
    endtask

    task automatic t_reset();
        check("R1 priv", {30'd0, priv_o}, 32'd3);
        check("R1 pc", pc_o, RST_PC);
        check("R1 mvec", mvec_o, MVEC0);
        check("R1 resv", {31'd0, resv_o}, 32'd0);
        check("R1 status", status_o, 32'd0);
    endtask

    task automatic t_machine_from_machine();
        exc_deleg = 32'h0000_0004;
        do_load(2'd1, 32'h8);
        do_trap(32'd2, 32'h40, 1, 32'hdead);
        check("R2 priv stays machine", {30'd0, priv_o}, 32'd3);
        check("R5 pc", pc_o, MVEC0);
        check("R5 mcause", m_cause_o, 32'd2);
        check("R5 mepc", m_epc_o, 32'h40);
        check("R5 mbad", m_bad_o, 32'hdead);
        check("R5 status", status_o, 32'h1880);
    endtask

    task automatic t_deleg_from_user();
        exc_deleg = 32'h0000_0100;
        do_load(2'd0, 32'd0);
        do_load(2'd1, 32'h1);
        do_resv();
        check("R8 resv set", {31'd0, resv_o}, 32'd1);
        do_trap(32'd8, 32'h84, 0, 32'hbeef);
        check("R4 priv supv", {30'd0, priv_o}, 32'd1);
        check("R3 pc aligned", pc_o, 32'h200);
        check("R3 scause", s_cause_o, 32'd8);
        check("R3 sepc", s_epc_o, 32'h84);
        check("R3 sbad unchanged", s_bad_o, 32'd0);
        check("R4 status", status_o, 32'h21);
        check("R8 resv cleared", {31'd0, resv_o}, 32'd0);
    endtask

    task automatic t_irq_routing();
        irq_deleg = 32'h0000_0020;
        exc_deleg = 32'h0000_0200;
        do_trap(32'h8000_0005, 32'h90, 1, 32'h77);
        check("R6 irq delegated", {30'd0, priv_o}, 32'd1);
        check("R6 scause", s_cause_o, 32'h8000_0005);
        check("R3 sbad written", s_bad_o, 32'h77);
        check("R4 status from supv", status_o, 32'h101);
        do_trap(32'h8000_0009, 32'h94, 0, 32'h0);
        check("R6 irq uses irq mask", {30'd0, priv_o}, 32'd3);
        check("R6 mcause", m_cause_o, 32'h8000_0009);
        check("R5 status from supv", status_o, 32'h901);
    endtask

    task automatic t_range();
        exc_deleg = 32'hffff_ffff;
        do_load(2'd0, 32'd1);
        do_trap(32'd40, 32'ha0, 0, 32'h0);
        check("R2 out of range index", {30'd0, priv_o}, 32'd3);
        check("R2 mcause", m_cause_o, 32'd40);
    endtask

    task automatic t_debug();
        exc_deleg = 32'h0;
        do_load(2'd0, 32'd0);
        do_resv();
        dbg_attached = 1;
        do_trap(32'd3, 32'hb0, 0, 32'h0);
        dbg_attached = 0;
        check("R7 pc", pc_o, DBGPC);
        check("R7 dpc", dbg_pc_o, 32'hb0);
        check("R7 dcause", {29'd0, dbg_cause_o}, 32'd1);
        check("R7 priv kept", {30'd0, priv_o}, 32'd0);
        check("R7 resv kept", {31'd0, resv_o}, 32'd1);
        check("R7 mcause kept", m_cause_o, 32'd40);
        do_trap(32'd3, 32'hb4, 0, 32'h0);
        check("R7 no debugger machine", m_cause_o, 32'd3);
        check("R7 no debugger pc", pc_o, MVEC0);
    endtask

    task automatic t_collision();
        do_load(2'd0, 32'd1);
        do_resv();
        @(negedge clk);
        trap_valid = 1; trap_cause = 32'd6; trap_pc = 32'hc0;
        ld_en = 1; ld_sel = 2'd0; ld_data = 32'd0; resv_set = 1;
        @(negedge clk);
        trap_valid = 0; ld_en = 0; resv_set = 0;
        check("R10 trap wins priv", {30'd0, priv_o}, 32'd3);
        check("R10 resv dropped", {31'd0, resv_o}, 32'd0);
        check("R10 mepc", m_epc_o, 32'hc0);
    endtask

    task automatic t_loads();
        do_load(2'd2, 32'h303);
        check("R12 mvec aligned", mvec_o, 32'h300);
        do_load(2'd0, 32'd2);
        check("R9 illegal priv ignored", {30'd0, priv_o}, 32'd3);
        do_load(2'd1, 32'hffff_ffff);
        check("R11 status mask", status_o, 32'h19bb);
        do_load(2'd3, 32'h0);
        check("R9 none select", status_o, 32'h19bb);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_machine_from_machine();
        t_deleg_from_user();
        t_irq_routing();
        t_range();
        t_debug();
        t_collision();
        t_loads();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule